// File: doc/BRIEF.md
# Prefix-Aware Instruction Length Decoder

This block sits behind instruction fetch and measures one instruction at a time from a window of up to 16 bytes. The window is given in memory order, with byte 0 in bits [7:0]. The block recognises the operand-size prefix (0x66) and the address-size prefix (0x67) in any order. It then classifies the opcode, reads the ModRM byte where the opcode has one, and adds the prefix, opcode, ModRM, displacement and immediate sizes to give the instruction's length. When the decoded instruction carries no prefix that alters its length, the result appears in the same cycle the window is presented. The window is also taken in that cycle.

A prefix can change the instruction's length, and 0x66 in front of the 0xF7 group counts as such a prefix even though it changes nothing. When either happens, the block models the slow length-decode path. It drops `in_ready`, so the fetch side keeps the same window, and it reports nothing for a fixed number of cycles. After that it releases the result. One such activation costs `SLOW_PEN` cycles (5). Two activations on one instruction, one from each prefix, cost `DOUBLE_PEN` cycles (11). Each activation produces a one-cycle `lcp_event` pulse that a performance counter can count. Windows the block cannot measure are answered at once with an error flag instead of a length.

Top module: `ild_lcp_decoder`

## Requirements
- R1: Supported opcodes and their lengths, where Z is a size of 4 bytes, or 2 bytes with 0x66:
  - 0x90 and 0xC3 are one byte.
  - 0x05, 0x35 and 0xB8..0xBF take an immediate of size Z and no ModRM.
  - 0x89 and 0x8B take a ModRM and no immediate.
  - 0x81 takes a ModRM and a Z immediate.
  - 0x83 takes a ModRM and a one-byte immediate.
  - 0xF7 takes a ModRM.

  An instruction with no activation gives `out_valid`=1, `in_ready`=1 and `out_len` = total bytes in the cycle it is presented.
- R2: With 0x66 before an opcode that has a Z immediate (0x05, 0x35, 0xB8..0xBF, 0x81), the immediate is 2 bytes. `out_lcp`=1, and the result comes exactly 5 cycles later than without a stall.
- R3: 0x66 before 0xF7 always counts as one activation (`out_lcp`=1, 5 stall cycles), including ModRM reg values that carry no immediate.
- R4: For 0xF7 the ModRM reg field is bits [5:3]. Values 0 and 1 carry a Z immediate. Values 2 to 7 carry none.
- R5: ModRM has mod in bits [7:6] and rm in bits [2:0]. mod=3 has no displacement and mod=1 has one byte.
  - Without 0x67: mod=2 takes 4 bytes and mod=0 with rm=5 takes 4 bytes.
  - With 0x67: mod=2 takes 2 bytes, mod=0 with rm=6 takes 2 bytes, and mod=0 with rm=5 takes none.

  0x67 counts as one activation exactly when the displacement size differs between the two modes, which means mod=2, or mod=0 with rm 5 or 6.
- R6: When both prefixes each cause an activation, `out_lcp`=2 and the stall lasts 11 cycles.
- R7: `lcp_event` pulses for one cycle in the first cycle an activating instruction is presented. For a double activation it pulses again 5 cycles later. This gives exactly `out_lcp` pulses per instruction.
- R8: While stalling, `in_ready`=0 and `out_valid`=0. The result is given from the held window in the release cycle.
- R9: Any of the following sets `out_valid`=1, `out_err`=1, `out_len`=0 and `out_lcp`=0 in the same cycle, with no stall and no event:
  - more than `MAX_PFX` (4) leading prefixes;
  - a length greater than `in_count`;
  - an unsupported opcode;
  - a SIB form, which is rm=4 with mod≠3 and no 0x67.
- R10: A prefix that does not change the length causes no activation. Examples are 0x66 before 0x83, 0x89, 0x8B or 0x90, and 0x67 before an opcode without ModRM or with mod=1 or mod=3.
- R11: After reset with no input: `in_ready`=1, `out_valid`=0 and `lcp_event`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fetch window presented |
| in_bytes | input | 128 | Window bytes, byte 0 at bits [7:0] |
| in_count | input | 5 | Number of valid bytes in the window |
| in_ready | output | 1 | Window consumed this cycle |
| out_valid | output | 1 | Decode result valid |
| out_len | output | 5 | Instruction length in bytes (0 on error) |
| out_err | output | 1 | Decode error |
| out_lcp | output | 2 | Number of slow-decode activations (0..2) |
| lcp_event | output | 1 | One pulse per slow-decode activation |

## Verification
The bench covers the cases where a prefix looks length-changing but is not, such as 0x66 before imm8 or no-immediate forms, and 0x67 with an 8-bit displacement. A decoder that keys on the prefix alone would stall on these and return late. It covers 0x67 with mod=0 and rm=5, where the displacement disappears, and rm=6, where one appears. A design that reused the 32-bit table would give a wrong length and miss the activation. It covers double activation, where a design that saturates or sums penalties wrongly would release at 5 or 10 cycles or pulse the event only once. It covers the error boundaries: four prefixes against five, and a window exactly full against one byte short. A wrong comparison there either reports a length past the window or rejects a legal instruction.

// File: rtl/ild_pkg.sv
package ild_pkg;

    typedef enum logic [2:0] {
        OC_BARE,
        OC_ACC_IMMZ,
        OC_MRM,
        OC_MRM_IMMZ,
        OC_MRM_IMM8,
        OC_GRP3,
        OC_BAD
    } opc_class_e;

    typedef struct packed {
        logic       bad;
        logic       has_mrm;
        logic [2:0] disp_len;
        logic [2:0] imm_len;
        logic       osz_act;
        logic       asz_act;
    } body_info_t;

    localparam logic [7:0] PFX_OSZ = 8'h66;
    localparam logic [7:0] PFX_ASZ = 8'h67;

    function automatic opc_class_e classify(input logic [7:0] op);
        opc_class_e c;
        if (op[7:3] == 5'b10111) begin
            c = OC_ACC_IMMZ;
        end else begin
            case (op)
                8'h90, 8'hC3: c = OC_BARE;
                8'h05, 8'h35: c = OC_ACC_IMMZ;
                8'h89, 8'h8B: c = OC_MRM;
                8'h81:        c = OC_MRM_IMMZ;
                8'h83:        c = OC_MRM_IMM8;
                8'hF7:        c = OC_GRP3;
                default:      c = OC_BAD;
            endcase
        end
        return c;
    endfunction

    function automatic logic [2:0] disp_wide(input logic [1:0] md, input logic [2:0] rm);
        logic [2:0] d;
        case (md)
            2'd0:    d = (rm == 3'd5) ? 3'd4 : 3'd0;
            2'd1:    d = 3'd1;
            2'd2:    d = 3'd4;
            default: d = 3'd0;
        endcase
        return d;
    endfunction

    function automatic logic [2:0] disp_narrow(input logic [1:0] md, input logic [2:0] rm);
        logic [2:0] d;
        case (md)
            2'd0:    d = (rm == 3'd6) ? 3'd2 : 3'd0;
            2'd1:    d = 3'd1;
            2'd2:    d = 3'd2;
            default: d = 3'd0;
        endcase
        return d;
    endfunction

    function automatic logic is_sib(input logic [1:0] md, input logic [2:0] rm);
        return (md != 2'd3) && (rm == 3'd4);
    endfunction

endpackage

// File: rtl/ild_prefix_scan.sv
module ild_prefix_scan
    import ild_pkg::*;
#(
    parameter int WIN     = 16,
    parameter int MAX_PFX = 4,
    parameter int CW      = $clog2(MAX_PFX + 2)
) (
    input  logic [WIN*8-1:0] bytes_i,
    output logic [CW-1:0]    pfx_cnt_o,
    output logic             has_osz_o,
    output logic             has_asz_o,
    output logic             overflow_o
);
    localparam int SCAN = (MAX_PFX + 1 < WIN) ? MAX_PFX + 1 : WIN;

    always_comb begin
        logic       run;
        logic [7:0] b;
        int         cnt;
        run        = 1'b1;
        cnt        = 0;
        has_osz_o  = 1'b0;
        has_asz_o  = 1'b0;
        for (int i = 0; i < SCAN; i++) begin
            b = bytes_i[i*8 +: 8];
            if (run && (b == PFX_OSZ || b == PFX_ASZ)) begin
                cnt++;
                if (b == PFX_OSZ) has_osz_o = 1'b1;
                else              has_asz_o = 1'b1;
            end else begin
                run = 1'b0;
            end
        end
        overflow_o = (cnt > MAX_PFX);
        pfx_cnt_o  = CW'(cnt);
    end
endmodule

// File: rtl/ild_body_decode.sv
module ild_body_decode
    import ild_pkg::*;
(
    input  logic [7:0] opc_i,
    input  logic [7:0] mrm_i,
    input  logic       has_osz_i,
    input  logic       has_asz_i,
    output body_info_t info_o
);
    opc_class_e cls;
    logic [1:0] md;
    logic [2:0] rg, rm;
    logic [2:0] immz;
    logic [2:0] dw, dn;

    assign cls  = classify(opc_i);
    assign md   = mrm_i[7:6];
    assign rg   = mrm_i[5:3];
    assign rm   = mrm_i[2:0];
    assign immz = has_osz_i ? 3'd2 : 3'd4;
    assign dw   = disp_wide(md, rm);
    assign dn   = disp_narrow(md, rm);

    always_comb begin
        info_o = '0;
        case (cls)
            OC_BARE: ;
            OC_ACC_IMMZ: begin
                info_o.imm_len = immz;
                info_o.osz_act = has_osz_i;
            end
            OC_MRM: info_o.has_mrm = 1'b1;
            OC_MRM_IMMZ: begin
                info_o.has_mrm = 1'b1;
                info_o.imm_len = immz;
                info_o.osz_act = has_osz_i;
            end
            OC_MRM_IMM8: begin
                info_o.has_mrm = 1'b1;
                info_o.imm_len = 3'd1;
            end
            OC_GRP3: begin
                info_o.has_mrm = 1'b1;
                info_o.imm_len = (rg[2:1] == 2'b00) ? immz : 3'd0;
                info_o.osz_act = has_osz_i;
            end
            default: info_o.bad = 1'b1;
        endcase
        if (info_o.has_mrm) begin
            info_o.disp_len = has_asz_i ? dn : dw;
            info_o.asz_act  = has_asz_i && (dn != dw);
            if (!has_asz_i && is_sib(md, rm)) info_o.bad = 1'b1;
        end
    end
endmodule

// File: rtl/ild_stall_ctl.sv
module ild_stall_ctl #(
    parameter int SLOW_PEN   = 5,
    parameter int DOUBLE_PEN = 11,
    parameter int KW         = $clog2(DOUBLE_PEN + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [1:0] act_i,
    output logic       in_ready,
    output logic       out_valid,
    output logic       lcp_event
);
    typedef enum logic {ST_IDLE, ST_HOLD} st_e;
    localparam logic [KW-1:0] SECOND_AT = KW'(DOUBLE_PEN - SLOW_PEN);

    st_e          st, st_nx;
    logic [KW-1:0] cnt, cnt_nx;
    logic          dbl, dbl_nx;

    always_comb begin
        st_nx     = st;
        cnt_nx    = cnt;
        dbl_nx    = dbl;
        in_ready  = 1'b1;
        out_valid = in_valid;
        lcp_event = 1'b0;
        case (st)
            ST_IDLE: begin
                if (in_valid && act_i != 2'd0) begin
                    in_ready  = 1'b0;
                    out_valid = 1'b0;
                    lcp_event = 1'b1;
                    st_nx     = ST_HOLD;
                    dbl_nx    = (act_i == 2'd2);
                    cnt_nx    = (act_i == 2'd2) ? KW'(DOUBLE_PEN - 1) : KW'(SLOW_PEN - 1);
                end
            end
            default: begin
                if (cnt != '0) begin
                    in_ready  = 1'b0;
                    out_valid = 1'b0;
                    lcp_event = dbl && (cnt == SECOND_AT);
                    cnt_nx    = cnt - 1'b1;
                end else begin
                    st_nx = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
            dbl <= 1'b0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            dbl <= dbl_nx;
        end
    end

    p_count_steps_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && cnt != '0) |=> (st == ST_HOLD && cnt == $past(cnt) - 1'b1));
    p_event_enters_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && lcp_event) |=> (st == ST_HOLD));
    p_hold_releases_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && cnt == '0) |=> (st == ST_IDLE));
endmodule

// File: rtl/ild_lcp_decoder.sv
module ild_lcp_decoder
    import ild_pkg::*;
#(
    parameter int WIN        = 16,
    parameter int MAX_PFX    = 4,
    parameter int SLOW_PEN   = 5,
    parameter int DOUBLE_PEN = 11,
    parameter int LW         = $clog2(WIN + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [WIN*8-1:0] in_bytes,
    input  logic [LW-1:0]  in_count,
    output logic           in_ready,
    output logic           out_valid,
    output logic [LW-1:0]  out_len,
    output logic           out_err,
    output logic [1:0]     out_lcp,
    output logic           lcp_event
);
    localparam int CW = $clog2(MAX_PFX + 2);

    logic [CW-1:0] pfx_cnt;
    logic          has_osz, has_asz, pfx_over;
    logic [7:0]    opc_b, mrm_b;
    body_info_t    body;
    int unsigned   total;
    logic          bad;
    logic [1:0]    act;

    function automatic logic [7:0] pick(input logic [WIN*8-1:0] w, input int unsigned idx);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 0; i < WIN; i++) begin
            if (idx == i) r = w[i*8 +: 8];
        end
        return r;
    endfunction

    ild_prefix_scan #(.WIN(WIN), .MAX_PFX(MAX_PFX), .CW(CW)) u_scan (
        .bytes_i    (in_bytes),
        .pfx_cnt_o  (pfx_cnt),
        .has_osz_o  (has_osz),
        .has_asz_o  (has_asz),
        .overflow_o (pfx_over)
    );

    assign opc_b = pick(in_bytes, 32'(pfx_cnt));
    assign mrm_b = pick(in_bytes, 32'(pfx_cnt) + 1);

    ild_body_decode u_body (
        .opc_i     (opc_b),
        .mrm_i     (mrm_b),
        .has_osz_i (has_osz),
        .has_asz_i (has_asz),
        .info_o    (body)
    );

    always_comb begin
        total = 32'(pfx_cnt) + 1 + 32'(body.has_mrm) + 32'(body.disp_len) + 32'(body.imm_len);
        bad   = pfx_over || body.bad || (total > 32'(in_count));
        act   = bad ? 2'd0 : (2'(body.osz_act) + 2'(body.asz_act));
    end

    ild_stall_ctl #(.SLOW_PEN(SLOW_PEN), .DOUBLE_PEN(DOUBLE_PEN)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .act_i     (act),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .lcp_event (lcp_event)
    );

    assign out_err = out_valid && bad;
    assign out_len = (out_valid && !bad) ? LW'(total) : '0;
    assign out_lcp = out_valid ? act : 2'd0;

    p_err_same_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (out_valid && in_ready && out_len == '0 && !lcp_event));
    p_len_in_window_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_err) |-> (out_len != '0 && out_len <= in_count));
    p_lcp_needs_prefix_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_lcp != 2'd0) |-> (has_osz || has_asz));
endmodule

// File: tb/sim_ild_lcp_decoder.sv
module sim_ild_lcp_decoder;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    len;
        bit    err;
        int    act;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] in_bytes = '0;
    logic [4:0]   in_count = '0;
    logic         in_ready, out_valid, out_err, lcp_event;
    logic [4:0]   out_len;
    logic [1:0]   out_lcp;

    int   checks = 0;
    int   fails = 0;
    int   evts = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ild_lcp_decoder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bytes(in_bytes), .in_count(in_count),
        .in_ready(in_ready), .out_valid(out_valid), .out_len(out_len), .out_err(out_err),
        .out_lcp(out_lcp), .lcp_event(lcp_event)
    );

    task automatic check(input bit ok, input string what, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act_v, exp_v);
        end
    endtask

    function automatic logic [127:0] mk(input logic [7:0] b0, input logic [7:0] b1 = 0,
        input logic [7:0] b2 = 0, input logic [7:0] b3 = 0, input logic [7:0] b4 = 0,
        input logic [7:0] b5 = 0, input logic [7:0] b6 = 0, input logic [7:0] b7 = 0);
        return {64'h0, b7, b6, b5, b4, b3, b2, b1, b0};
    endfunction

    // Driver: pushes expectation, holds the window until taken, counts stall cycles.
    task automatic send(input logic [127:0] b, input int n, input int len, input bit err,
                        input int act, input string tag);
        int   stall = 0;
        exp_t e;
        e.len = len; e.err = err; e.act = act; e.tag = tag;
        sb.push_back(e);
        @(posedge clk); #1;
        in_valid = 1'b1; in_bytes = b; in_count = 5'(n);
        forever begin
            @(negedge clk);
            if (in_ready) break;
            if (out_valid) check(1'b0, {tag, " R8 out_valid during stall"}, 1, 0);
            stall++;
        end
        check(stall == ((act == 0) ? 0 : (act == 1 ? 5 : 11)), {tag, " stall cycles"},
              stall, (act == 0) ? 0 : (act == 1 ? 5 : 11));
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    // Monitor: pops and compares on every produced result.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (lcp_event) evts++;
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R8 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(out_len == 5'(e.len), {e.tag, " length"}, int'(out_len), e.len);
                    check(out_err == e.err, {e.tag, " error flag"}, int'(out_err), int'(e.err));
                    check(out_lcp == 2'(e.act), {e.tag, " activations"}, int'(out_lcp), e.act);
                    check(evts == e.act, {e.tag, " R7 event pulses"}, evts, e.act);
                end
                evts = 0;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R11 in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R11 out_valid after reset", int'(out_valid), 0);
        check(lcp_event == 1'b0, "R11 lcp_event after reset", int'(lcp_event), 0);

        send(mk(8'h35, 8'hFF, 8'hFF, 8'h00, 8'h00), 16, 5, 0, 0, "R1 xor imm32");
        send(mk(8'h90), 16, 1, 0, 0, "R1 nop");
        send(mk(8'hC3), 1, 1, 0, 0, "R1 ret exact window");
        send(mk(8'hB8, 1, 2, 3, 4), 5, 5, 0, 0, "R1 mov imm32 exact window");
        send(mk(8'h66, 8'h35, 8'hFF, 8'hFF), 16, 4, 0, 1, "R2 xor imm16");
        send(mk(8'h66, 8'hBB, 8'h34, 8'h12), 16, 4, 0, 1, "R2 mov imm16");
        send(mk(8'h66, 8'h66, 8'h35, 8'hFF, 8'hFF), 16, 5, 0, 1, "R2 repeated prefix");
        send(mk(8'h66, 8'h81, 8'hC1, 8'h01, 8'h00), 16, 5, 0, 1, "R2 grp1 imm16");
        send(mk(8'h66, 8'hF7, 8'hD8), 16, 3, 0, 1, "R3 false lcp neg");
        send(mk(8'h66, 8'hF7, 8'hD0), 16, 3, 0, 1, "R3 false lcp not");
        send(mk(8'hF7, 8'hD8), 16, 2, 0, 0, "R4 neg no prefix");
        send(mk(8'hF7, 8'hC0, 1, 2, 3, 4), 16, 6, 0, 0, "R4 test imm32");
        send(mk(8'h66, 8'hF7, 8'hC0, 8'h34, 8'h12), 16, 5, 0, 1, "R4 test imm16");
        send(mk(8'h8B, 8'h05, 1, 2, 3, 4), 16, 6, 0, 0, "R5 disp32 absolute");
        send(mk(8'h67, 8'h8B, 8'h05), 16, 3, 0, 1, "R5 rm5 loses disp");
        send(mk(8'h67, 8'h8B, 8'h06, 8'h34, 8'h12), 16, 5, 0, 1, "R5 rm6 gains disp16");
        send(mk(8'h67, 8'h89, 8'h45, 8'h08), 16, 4, 0, 0, "R10 addr prefix disp8");
        send(mk(8'h67, 8'h8B, 8'h04), 16, 3, 0, 0, "R5 rm4 no sib narrow");
        send(mk(8'h66, 8'h67, 8'h81, 8'h80, 8'h11, 8'h22, 8'h33, 8'h44), 8, 8, 0, 2, "R6 double grp1");
        send(mk(8'h67, 8'h66, 8'hF7, 8'h98, 8'h10, 8'h20), 16, 6, 0, 2, "R6 double false lcp");
        send(mk(8'h66, 8'h67, 8'h35, 8'hFF, 8'hFF), 16, 5, 0, 1, "R10 addr prefix no modrm");
        send(mk(8'h66, 8'h83, 8'hC0, 8'h01), 16, 4, 0, 0, "R10 imm8 unaffected");
        send(mk(8'h66, 8'h89, 8'hC8), 16, 3, 0, 0, "R10 reg move");
        send(mk(8'h66, 8'h66, 8'h66, 8'h66, 8'h90), 16, 5, 0, 0, "R10 four prefixes ok");
        send(mk(8'h66, 8'h66, 8'h66, 8'h66, 8'h66, 8'h90), 16, 0, 1, 0, "R9 prefix overflow");
        send(mk(8'h35, 8'hFF, 8'hFF), 3, 0, 1, 0, "R9 window short");
        send(mk(8'h66, 8'h35, 8'hFF), 3, 0, 1, 0, "R9 short no stall");
        send(mk(8'h8B, 8'h04, 8'h24), 16, 0, 1, 0, "R9 sib form");
        send(mk(8'h0F, 8'h05), 16, 0, 1, 0, "R9 unknown opcode");
        send(mk(8'h35, 8'h01, 8'h00, 8'h00, 8'h00), 16, 5, 0, 0, "R1 after errors");

        repeat (3) @(posedge clk);
        check(sb.size() == 0, "R1 all results produced", sb.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule